// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This block sits between a 32-bit register datapath and a word-wide data memory. It forms a byte address from a base register value and a signed 16-bit displacement. On a load it picks the addressed byte, halfword or full word out of the memory word that was read. It then widens the result to the register width, filling the upper bits either with copies of the sign bit or with zeros.

On a store it copies the source data onto every lane the access can land on and raises one write strobe per addressed byte lane. Halfword and word accesses that are not naturally aligned raise a flag. A flagged store writes nothing, and a flagged load returns zero.

The unit is purely combinational. Byte lane numbering is big-endian by default, so the lowest byte address in a word maps to the most significant lane. A parameter selects the little-endian variant instead.

Top module: `lsu_lane_unit`

## Requirements
- R1: `addr_o` equals `base_i` plus `offset_i` sign-extended from bit 15, computed modulo 2^32, for every request or no request.
- R2: A byte load (`size_i`=00) with `unsigned_i`=0 returns the addressed byte with its bit 7 copied into bits 31..8. Address offset 0 selects memory bits 31..24, offset 1 selects 23..16, offset 2 selects 15..8 and offset 3 selects 7..0; for example, a byte of A7h reads as FFFFFFA7h.
- R3: A byte load with `unsigned_i`=1 returns the addressed byte with bits 31..8 cleared.
- R4: A halfword load (`size_i`=01) returns memory bits 31..16 when address bit 1 is 0 and bits 15..0 when it is 1. The upper 16 bits are copies of bit 15 when `unsigned_i`=0 and zeros when `unsigned_i`=1.
- R5: A word load (`size_i`=10 or 11) returns the memory word unchanged, whatever the value of `unsigned_i`.
- R6: A byte store drives exactly one strobe. Bit i of `mem_be_o` covers data bits 8i+7..8i, so offset 0 sets bit 3 and offset 3 sets bit 0. `mem_wdata_o` carries byte 7..0 of the source in all four lanes.
- R7: A halfword store drives `mem_be_o`=1100 when address bit 1 is 0 and 0011 when it is 1, with source bits 15..0 in both halves of `mem_wdata_o`.
- R8: A word store drives `mem_be_o`=1111 and passes the source word through unchanged.
- R9: A halfword request with address bit 0 set, or a word request with either of address bits 1..0 set, raises `misalign_o`. In that case `mem_be_o` is 0000 and `load_data_o` is zero. Byte requests never raise the flag.
- R10: With neither `load_i` nor `store_i` asserted, `misalign_o` is 0 and `mem_be_o` is 0000, even for an address that would be misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| unsigned_i | input | 1 | Zero-extend sub-word loads |
| load_i | input | 1 | Load request |
| store_i | input | 1 | Store request |
| store_data_i | input | 32 | Source register value for stores |
| mem_rdata_i | input | 32 | Word read from memory |
| addr_o | output | 32 | Effective byte address |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| mem_be_o | output | 4 | Per-lane write strobes |
| load_data_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Alignment violation flag |

## Verification
The bench runs every size, signedness and low-address combination against a small word memory model. It uses data whose sign bits sit in every lane, and negative and wrapping displacements. A unit that reversed the lane order would read offset 0 from bits 7..0 and strobe the wrong byte of the model word. Extension based on the wrong bit, or extension on unsigned loads, would corrupt bytes such as 80h and A7h. A missing misalignment check would modify memory on an odd halfword address, and a carry that was not propagated would give a wrong address once the base wraps past 2^32.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

   // Access width encoding shared by all sub-units
   typedef enum logic [1:0] {
      ACC_BYTE = 2'b00,
      ACC_HALF = 2'b01,
      ACC_WORD = 2'b10,
      ACC_FULL = 2'b11
   } acc_size_e;

endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map #(
   parameter int LANE_IDX_W = 2,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [LANE_IDX_W-1:0] lane_off_i,
   output logic [LANE_IDX_W-1:0] byte_lane_o,
   output logic [LANE_IDX_W-2:0] half_lane_o
);

   generate
      if (BIG_ENDIAN) begin : g_big
         // lowest address lands in the most significant lane
         assign byte_lane_o = ~lane_off_i;
         assign half_lane_o = ~lane_off_i[LANE_IDX_W-1:1];
      end else begin : g_little
         assign byte_lane_o = lane_off_i;
         assign half_lane_o = lane_off_i[LANE_IDX_W-1:1];
      end
   endgenerate

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import lsu_lane_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int OFF_W      = 16,
   parameter int LANE_IDX_W = 2
) (
   input  logic [ADDR_W-1:0]     base_i,
   input  logic [OFF_W-1:0]      offset_i,
   input  acc_size_e             size_i,
   input  logic                  active_i,
   output logic [ADDR_W-1:0]     ea_o,
   output logic [LANE_IDX_W-1:0] lane_off_o,
   output logic                  misalign_o
);

   localparam int EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] off_ext;
   logic              bad_align;

   assign off_ext    = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
   assign ea_o       = base_i + off_ext;
   assign lane_off_o = ea_o[LANE_IDX_W-1:0];

   always_comb begin
      unique case (size_i)
         ACC_BYTE: bad_align = 1'b0;
         ACC_HALF: bad_align = lane_off_o[0];
         default:  bad_align = |lane_off_o;
      endcase
   end

   assign misalign_o = active_i & bad_align;

   always_comb begin
      if (!$isunknown({size_i, active_i, lane_off_o})) begin
         // R9
         byte_never_misaligned_chk: assert (!(misalign_o && size_i == ACC_BYTE));
         // R10
         idle_no_flag_chk: assert (active_i || !misalign_o);
      end
   end

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
   import lsu_lane_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  acc_size_e                      size_i,
   input  logic [$clog2(DATA_W/8)-1:0]    lane_off_i,
   input  logic                           write_en_i,
   input  logic [DATA_W-1:0]              data_i,
   output logic [DATA_W-1:0]              wdata_o,
   output logic [DATA_W/8-1:0]            be_o
);

   localparam int LANES      = DATA_W / 8;
   localparam int HALVES     = LANES / 2;
   localparam int LANE_IDX_W = $clog2(LANES);
   localparam int HALF_IDX_W = LANE_IDX_W - 1;

   logic [LANE_IDX_W-1:0] byte_lane;
   logic [HALF_IDX_W-1:0] half_lane;
   logic [LANES-1:0]      byte_mask;
   logic [LANES-1:0]      half_mask;
   logic [LANES-1:0]      be_raw;

   lsu_lane_map #(
      .LANE_IDX_W (LANE_IDX_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_map (
      .lane_off_i  (lane_off_i),
      .byte_lane_o (byte_lane),
      .half_lane_o (half_lane)
   );

   generate
      for (genvar gi = 0; gi < LANES; gi++) begin : g_mask
         assign byte_mask[gi] = (byte_lane == LANE_IDX_W'(gi));
         assign half_mask[gi] = (half_lane == HALF_IDX_W'(gi / 2));
      end
   endgenerate

   always_comb begin
      unique case (size_i)
         ACC_BYTE: begin
            be_raw  = byte_mask;
            wdata_o = {LANES{data_i[7:0]}};
         end
         ACC_HALF: begin
            be_raw  = half_mask;
            wdata_o = {HALVES{data_i[15:0]}};
         end
         default: begin
            be_raw  = '1;
            wdata_o = data_i;
         end
      endcase
   end

   assign be_o = write_en_i ? be_raw : '0;

   always_comb begin
      if (!$isunknown({size_i, write_en_i, lane_off_i})) begin
         // R6
         byte_single_strobe_chk: assert (!(write_en_i && size_i == ACC_BYTE) || $countones(be_o) == 1);
         // R7
         half_two_strobes_chk: assert (!(write_en_i && size_i == ACC_HALF) || $countones(be_o) == 2);
         // R8
         word_all_strobes_chk: assert (!(write_en_i && size_i[1]) || (&be_o));
      end
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_lane_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  acc_size_e                      size_i,
   input  logic [$clog2(DATA_W/8)-1:0]    lane_off_i,
   input  logic                           unsigned_i,
   input  logic                           kill_i,
   input  logic [DATA_W-1:0]              rdata_i,
   output logic [DATA_W-1:0]              result_o
);

   localparam int LANES      = DATA_W / 8;
   localparam int HALVES     = LANES / 2;
   localparam int LANE_IDX_W = $clog2(LANES);
   localparam int HALF_IDX_W = LANE_IDX_W - 1;

   logic [LANE_IDX_W-1:0] byte_lane;
   logic [HALF_IDX_W-1:0] half_lane;
   logic [7:0]            lane_b [LANES];
   logic [15:0]           lane_h [HALVES];
   logic [7:0]            pick_b;
   logic [15:0]           pick_h;
   logic                  fill_b;
   logic                  fill_h;
   logic [DATA_W-1:0]     ext;

   lsu_lane_map #(
      .LANE_IDX_W (LANE_IDX_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_map (
      .lane_off_i  (lane_off_i),
      .byte_lane_o (byte_lane),
      .half_lane_o (half_lane)
   );

   generate
      for (genvar gb = 0; gb < LANES; gb++) begin : g_bytes
         assign lane_b[gb] = rdata_i[8*gb +: 8];
      end
      for (genvar gh = 0; gh < HALVES; gh++) begin : g_halves
         assign lane_h[gh] = rdata_i[16*gh +: 16];
      end
   endgenerate

   assign pick_b = lane_b[byte_lane];
   assign pick_h = lane_h[half_lane];
   assign fill_b = ~unsigned_i & pick_b[7];
   assign fill_h = ~unsigned_i & pick_h[15];

   always_comb begin
      unique case (size_i)
         ACC_BYTE: ext = {{(DATA_W-8){fill_b}}, pick_b};
         ACC_HALF: ext = {{(DATA_W-16){fill_h}}, pick_h};
         default:  ext = rdata_i;
      endcase
   end

   assign result_o = kill_i ? '0 : ext;

   always_comb begin
      if (!$isunknown({size_i, unsigned_i, kill_i, lane_off_i, rdata_i})) begin
         // R3
         ubyte_zero_fill_chk: assert (!(!kill_i && size_i == ACC_BYTE && unsigned_i) || result_o[DATA_W-1:8] == '0);
         // R2
         sbyte_sign_fill_chk: assert (!(!kill_i && size_i == ACC_BYTE && !unsigned_i) ||
                                      result_o[DATA_W-1:7] == '0 || (&result_o[DATA_W-1:7]));
         // R5
         word_passthru_chk: assert (!(!kill_i && size_i[1]) || result_o == rdata_i);
      end
   end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
   import lsu_lane_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int OFF_W      = 16,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [ADDR_W-1:0]   base_i,
   input  logic [OFF_W-1:0]    offset_i,
   input  logic [1:0]          size_i,
   input  logic                unsigned_i,
   input  logic                load_i,
   input  logic                store_i,
   input  logic [DATA_W-1:0]   store_data_i,
   input  logic [DATA_W-1:0]   mem_rdata_i,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [DATA_W-1:0]   mem_wdata_o,
   output logic [DATA_W/8-1:0] mem_be_o,
   output logic [DATA_W-1:0]   load_data_o,
   output logic                misalign_o
);

   localparam int LANES      = DATA_W / 8;
   localparam int LANE_IDX_W = $clog2(LANES);

   generate
      if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
         $error("lsu_lane_unit: DATA_W must be a power of two of at least 32");
      end
      if (OFF_W < 2 || OFF_W >= ADDR_W) begin : g_bad_off_w
         $error("lsu_lane_unit: OFF_W must lie between 2 and ADDR_W-1");
      end
      if (ADDR_W < LANE_IDX_W + 1) begin : g_bad_addr_w
         $error("lsu_lane_unit: ADDR_W too narrow for the lane count");
      end
   endgenerate

   acc_size_e             size;
   logic                  active;
   logic                  misalign;
   logic [LANE_IDX_W-1:0] lane_off;

   assign size   = acc_size_e'(size_i);
   assign active = load_i | store_i;

   lsu_addr_gen #(
      .ADDR_W     (ADDR_W),
      .OFF_W      (OFF_W),
      .LANE_IDX_W (LANE_IDX_W)
   ) u_agen (
      .base_i     (base_i),
      .offset_i   (offset_i),
      .size_i     (size),
      .active_i   (active),
      .ea_o       (addr_o),
      .lane_off_o (lane_off),
      .misalign_o (misalign)
   );

   lsu_store_lane #(
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_store (
      .size_i     (size),
      .lane_off_i (lane_off),
      .write_en_i (store_i & ~misalign),
      .data_i     (store_data_i),
      .wdata_o    (mem_wdata_o),
      .be_o       (mem_be_o)
   );

   lsu_load_extract #(
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_load (
      .size_i     (size),
      .lane_off_i (lane_off),
      .unsigned_i (unsigned_i),
      .kill_i     (misalign),
      .rdata_i    (mem_rdata_i),
      .result_o   (load_data_o)
   );

   assign misalign_o = misalign;

   always_comb begin
      if (!$isunknown({load_i, store_i, size_i, addr_o})) begin
         // R9
         misalign_blocks_write_chk: assert (!misalign_o || mem_be_o == '0);
         // R10
         idle_no_strobe_chk: assert (store_i || mem_be_o == '0);
      end
   end

endmodule

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic [31:0] base_i = '0;
   logic [15:0] offset_i = '0;
   logic [1:0]  size_i = '0;
   logic        unsigned_i = 1'b0;
   logic        load_i = 1'b0;
   logic        store_i = 1'b0;
   logic [31:0] store_data_i = '0;
   logic [31:0] mem_rdata_i = '0;
   logic [31:0] addr_o;
   logic [31:0] mem_wdata_o;
   logic [3:0]  mem_be_o;
   logic [31:0] load_data_o;
   logic        misalign_o;

   int n_run  = 0;
   int n_fail = 0;
   int cycles = 0;

   logic [31:0] mem [4];

   lsu_lane_unit uut (
      .base_i       (base_i),
      .offset_i     (offset_i),
      .size_i       (size_i),
      .unsigned_i   (unsigned_i),
      .load_i       (load_i),
      .store_i      (store_i),
      .store_data_i (store_data_i),
      .mem_rdata_i  (mem_rdata_i),
      .addr_o       (addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .mem_be_o     (mem_be_o),
      .load_data_o  (load_data_o),
      .misalign_o   (misalign_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run = n_run + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: act=%08h exp=%08h (base=%08h off=%04h size=%0d u=%0b)",
                  req, act, exp, base_i, offset_i, size_i, unsigned_i);
      end
   endtask

   function automatic logic [31:0] pattern(input int i);
      case (i)
         0: return 32'h80A7_7F01;
         1: return 32'h1234_56F8;
         2: return 32'hFFFF_0000;
         default: return 32'h0000_8001;
      endcase
   endfunction

   function automatic logic [31:0] base_val(input int i);
      case (i)
         0: return 32'h0000_0100;
         1: return 32'h0000_0004;
         2: return 32'hFFFF_FFF0;
         default: return 32'h7FFF_FFFF;
      endcase
   endfunction

   function automatic logic [15:0] off_val(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'h0002;
         3: return 16'h0003;
         4: return 16'hFFFD;
         5: return 16'h7FFE;
         default: return 16'h8001;
      endcase
   endfunction

   logic [31:0] ea, old_w, exp_w, exp_ld, picked;
   logic        exp_mis;
   int          sh;

   task automatic compute_expect(input int sz, input int u);
      ea = base_i + {{16{offset_i[15]}}, offset_i};
      exp_mis = (sz == 1 && ea[0]) || (sz >= 2 && ea[1:0] != 2'b00);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) mem[i] = pattern(i);
      @(posedge clk);
      @(negedge clk);
      // R10: idle, reset-like state
      check(mem_be_o == 4'h0, "R10", {28'h0, mem_be_o}, 32'h0);
      check(misalign_o == 1'b0, "R10", {31'h0, misalign_o}, 32'h0);

      for (int bi = 0; bi < 4; bi++)
      for (int oi = 0; oi < 7; oi++)
      for (int sz = 0; sz < 4; sz++)
      for (int u = 0; u < 2; u++)
      for (int pi = 0; pi < 4; pi++) begin
         // ---- load ----
         @(posedge clk);
         base_i = base_val(bi);
         offset_i = off_val(oi);
         size_i = 2'(sz);
         unsigned_i = u[0];
         load_i = 1'b1;
         store_i = 1'b0;
         store_data_i = pattern(3 - pi);
         compute_expect(sz, u);
         mem_rdata_i = mem[ea[3:2]] ^ pattern(pi);
         @(negedge clk);
         // R1
         check(addr_o == ea, "R1", addr_o, ea);
         check(misalign_o == exp_mis, "R9", {31'h0, misalign_o}, {31'h0, exp_mis});
         if (exp_mis) exp_ld = 32'h0;
         else if (sz == 0) begin
            sh = 8 * (3 - int'(ea[1:0]));
            picked = (mem_rdata_i >> sh) & 32'hFF;
            exp_ld = (u == 0 && picked[7]) ? (picked | 32'hFFFF_FF00) : picked;
         end else if (sz == 1) begin
            sh = 16 * (1 - int'(ea[1]));
            picked = (mem_rdata_i >> sh) & 32'hFFFF;
            exp_ld = (u == 0 && picked[15]) ? (picked | 32'hFFFF_0000) : picked;
         end else exp_ld = mem_rdata_i;
         // R2 R3 R4 R5 R9
         check(load_data_o == exp_ld,
               exp_mis ? "R9" : (sz == 0 ? (u == 0 ? "R2" : "R3") : (sz == 1 ? "R4" : "R5")),
               load_data_o, exp_ld);
         check(mem_be_o == 4'h0, "R10", {28'h0, mem_be_o}, 32'h0);

         // ---- store ----
         @(posedge clk);
         load_i = 1'b0;
         store_i = 1'b1;
         @(negedge clk);
         old_w = mem[ea[3:2]];
         for (int l = 0; l < 4; l++)
            if (mem_be_o[l]) mem[ea[3:2]][8*l +: 8] = mem_wdata_o[8*l +: 8];
         if (exp_mis) exp_w = old_w;
         else if (sz == 0) begin
            sh = 8 * (3 - int'(ea[1:0]));
            exp_w = (old_w & ~(32'hFF << sh)) | ((store_data_i & 32'hFF) << sh);
         end else if (sz == 1) begin
            sh = 16 * (1 - int'(ea[1]));
            exp_w = (old_w & ~(32'hFFFF << sh)) | ((store_data_i & 32'hFFFF) << sh);
         end else exp_w = store_data_i;
         // R6 R7 R8 R9
         check(mem[ea[3:2]] == exp_w,
               exp_mis ? "R9" : (sz == 0 ? "R6" : (sz == 1 ? "R7" : "R8")),
               mem[ea[3:2]], exp_w);
         if (!exp_mis && sz == 0)
            check(mem_be_o == 4'(4'b1000 >> ea[1:0]), "R6", {28'h0, mem_be_o}, {28'h0, 4'(4'b1000 >> ea[1:0])});
         if (!exp_mis && sz == 1)
            check(mem_be_o == (ea[1] ? 4'b0011 : 4'b1100), "R7", {28'h0, mem_be_o},
                  {28'h0, (ea[1] ? 4'b0011 : 4'b1100)});
         if (exp_mis)
            check(mem_be_o == 4'h0, "R9", {28'h0, mem_be_o}, 32'h0);

         // ---- idle with the same address ----
         @(posedge clk);
         store_i = 1'b0;
         @(negedge clk);
         check(mem_be_o == 4'h0 && misalign_o == 1'b0, "R10", {27'h0, misalign_o, mem_be_o}, 32'h0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule